// File: doc/BRIEF.md
# Two-Wire Serial Register Slave

This block is a two-wire serial slave that gives an external bus master read and write access to a bank of 26 eight-bit control registers, numbered 00h to 19h. The serial clock and data lines are sampled by a fast system clock, at least eight times the serial clock rate, through a short synchronizer chain. The block pulls the data line low through a single enable output and otherwise leaves it released. A level on the select pin picks one of two fixed 7-bit bus addresses, so two copies can share one bus.

A write transfer carries the bus address with the direction bit clear, then a base register number, then any number of data bytes. Each data byte is stored at the current register number, and the number then steps up by one, stopping at 19h. A read transfer starts at the base number left by the most recent write and steps the same way. A repeated start lets the master set the base and then turn the bus around for reading without releasing it.

Every register write also appears on the parallel side as a one-cycle strobe with its address and data. This strobe has no back-pressure: the consumer has to take it in the cycle it is high. A separate parallel read port returns any register's content combinationally.

Top module: `sreg_port`

## Requirements
- R1: A falling data line while the serial clock is high is a start and begins address decoding. A rising data line while the clock is high is a stop and returns the block to idle, with the data line released.
- R2: The bus address is binary 100110 followed by the select-pin level (4Ch with select low, 4Dh with select high). The first byte after a start holds the address in bits 7..1 and the direction in bit 0 (1 = read, 0 = write). On a match the block holds the data line low for the whole ninth clock pulse.
- R3: On an address mismatch the block leaves the data line high in the ninth pulse, returns to idle, and writes no register.
- R4: In a write transfer, the byte after the address is the base register number. Each following data byte is written to the current number, with one write strobe for each byte, and the number then increases by one.
- R5: Once the register number reaches 19h it stays there: further written bytes all land in 19h, and further read bytes all come from 19h.
- R6: A base number above 19h gets no acknowledge, and the previously stored base number is kept.
- R7: A read transfer returns the register at the most recently written base number first, then the following registers in ascending order.
- R8: When the master does not acknowledge a read byte, the block ends the read and leaves the data line released.
- R9: A start without a stop before it (a repeated start) restarts address decoding, so a write of the base number can be followed directly by a read.
- R10: The data-line pull output changes only while the synchronized serial clock is low.
- R11: After reset all registers read zero, the data line is released and no write strobe is issued.
- R12: Every byte is moved most significant bit first, in both directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the serial clock rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| addr_sel_i | input | 1 | Selects the low bit of the bus address |
| sda_pull_o | output | 1 | High pulls the data line low; low releases it |
| wr_stb_o | output | 1 | One-cycle strobe for each register write |
| wr_addr_o | output | 5 | Register number of the write |
| wr_data_o | output | 8 | Data byte of the write |
| host_raddr_i | input | 5 | Register number for the parallel read port |
| host_rdata_o | output | 8 | Content of the addressed register |

## Verification
Checked on every cycle: the data-line pull changes only while the synchronized clock is low, a detected stop leaves the sequencer idle, a detected start puts it at the first bit of address decoding, the register pointer never leaves 00h..19h, and a write strobe lands its byte in the bank. Only the bench's transfers can show the protocol as a whole. These are the acknowledge and refusal decisions for each bus address and base number, the order of bytes in bursts, saturation at 19h in both directions, keeping the base across a refused base, and turning the bus around with a repeated start.

// File: rtl/sreg_pkg.sv
`timescale 1ns/1ps
package sreg_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,   // waiting for a start
    ST_RX,     // shifting in a byte
    ST_ACK,    // holding the acknowledge bit
    ST_TX,     // shifting out a read byte
    ST_RACK    // waiting for the master's acknowledge
  } seq_state_e;

  typedef enum logic [1:0] {
    K_DEV,     // bus address byte
    K_REG,     // base register number
    K_DAT      // register data byte
  } byte_kind_e;
endpackage

// File: rtl/sreg_sync.sv
`timescale 1ns/1ps
module sreg_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_p,
  output logic stop_p
);
  // one extra stage keeps the previous synchronized value for edge detection
  localparam int DEPTH = STAGES + 1;

  logic [DEPTH-1:0] scl_sh, sda_sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh <= '1;
      sda_sh <= '1;
    end else begin
      scl_sh <= {scl_sh[DEPTH-2:0], scl_i};
      sda_sh <= {sda_sh[DEPTH-2:0], sda_i};
    end
  end

  logic scl_old, sda_old;
  assign scl_lvl = scl_sh[STAGES-1];
  assign sda_lvl = sda_sh[STAGES-1];
  assign scl_old = scl_sh[STAGES];
  assign sda_old = sda_sh[STAGES];

  assign scl_rise = scl_lvl & ~scl_old;
  assign scl_fall = ~scl_lvl & scl_old;
  assign start_p  = scl_lvl & scl_old & sda_old & ~sda_lvl;
  assign stop_p   = scl_lvl & scl_old & ~sda_old & sda_lvl;
endmodule

// File: rtl/sreg_bank.sv
`timescale 1ns/1ps
module sreg_bank #(
  parameter int NREG = 26,
  parameter int AW   = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic [AW-1:0] ra_addr,
  output logic [7:0]    ra_data,
  input  logic [AW-1:0] rb_addr,
  output logic [7:0]    rb_data
);
  logic [7:0] mem [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        mem[i] <= 8'h00;
      else if (wr_en && (wr_addr == AW'(i)))
        mem[i] <= wr_data;
    end
  end

  localparam logic [AW:0] LIMIT = (AW+1)'(NREG);

  assign ra_data = ({1'b0, ra_addr} < LIMIT) ? mem[ra_addr] : 8'h00;
  assign rb_data = ({1'b0, rb_addr} < LIMIT) ? mem[rb_addr] : 8'h00;

  // R4: a strobed byte is present in the bank on the following cycle
  p_bank_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (mem[$past(wr_addr)] == $past(wr_data)));
endmodule

// File: rtl/sreg_seq.sv
`timescale 1ns/1ps
module sreg_seq
  import sreg_pkg::*;
#(
  parameter int          NREG   = 26,
  parameter int          AW     = 5,
  parameter logic [5:0]  DEV_HI = 6'b100110
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_lvl,
  input  logic          sda_lvl,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_p,
  input  logic          stop_p,
  input  logic          addr_sel,
  input  logic [7:0]    rd_data,
  output logic [AW-1:0] rd_addr,
  output logic          wr_stb,
  output logic [AW-1:0] wr_addr,
  output logic [7:0]    wr_data,
  output logic          sda_pull
);
  localparam logic [AW-1:0] TOP  = AW'(NREG - 1);
  localparam logic [7:0]    TOP8 = 8'(NREG - 1);

  seq_state_e   st;
  byte_kind_e   kind;
  logic [3:0]   bitn;
  logic [7:0]   shreg;
  logic [7:0]   txb;
  logic [AW-1:0] ptr;
  logic         rw_q;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == TOP) ? p : p + 1'b1;
  endfunction

  assign rd_addr  = ptr;
  assign sda_pull = (st == ST_ACK) || ((st == ST_TX) && !txb[7]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      kind    <= K_DEV;
      bitn    <= '0;
      shreg   <= '0;
      txb     <= 8'hFF;
      ptr     <= '0;
      rw_q    <= 1'b0;
      wr_stb  <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      wr_stb <= 1'b0;
      if (start_p) begin
        st   <= ST_RX;
        kind <= K_DEV;
        bitn <= '0;
      end else if (stop_p) begin
        st <= ST_IDLE;
      end else begin
        unique case (st)
          ST_RX: begin
            if (scl_rise) begin
              shreg <= {shreg[6:0], sda_lvl};
              bitn  <= bitn + 4'd1;
            end else if (scl_fall && bitn == 4'd8) begin
              bitn <= '0;
              unique case (kind)
                K_DEV: begin
                  if (shreg[7:1] == {DEV_HI, addr_sel}) begin
                    rw_q <= shreg[0];
                    st   <= ST_ACK;
                  end else begin
                    st <= ST_IDLE;
                  end
                end
                K_REG: begin
                  if (shreg <= TOP8) begin
                    ptr <= shreg[AW-1:0];
                    st  <= ST_ACK;
                  end else begin
                    st <= ST_IDLE;
                  end
                end
                default: begin
                  wr_stb  <= 1'b1;
                  wr_addr <= ptr;
                  wr_data <= shreg;
                  ptr     <= step(ptr);
                  st      <= ST_ACK;
                end
              endcase
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              if (kind == K_DEV && rw_q) begin
                txb  <= rd_data;
                ptr  <= step(ptr);
                bitn <= '0;
                st   <= ST_TX;
              end else begin
                kind <= (kind == K_DEV) ? K_REG : K_DAT;
                st   <= ST_RX;
              end
            end
          end
          ST_TX: begin
            if (scl_fall) begin
              if (bitn == 4'd7) begin
                bitn <= '0;
                st   <= ST_RACK;
              end else begin
                txb  <= {txb[6:0], 1'b1};
                bitn <= bitn + 4'd1;
              end
            end
          end
          ST_RACK: begin
            if (scl_rise && sda_lvl) begin
              st <= ST_IDLE;
            end else if (scl_fall) begin
              txb <= rd_data;
              ptr <= step(ptr);
              st  <= ST_TX;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R10: the line drive only moves while the clock is low
  p_sda_scl_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_pull != $past(sda_pull)) |-> !scl_lvl);

  // R1: a stop always leaves the sequencer idle
  p_stop_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    stop_p |=> (st == ST_IDLE));

  // R9: a start, repeated or not, restarts address decoding
  p_start_decode_r9: assert property (@(posedge clk) disable iff (!rst_n)
    start_p |=> (st == ST_RX && kind == K_DEV && bitn == 4'd0));

  // R5: the register pointer never passes the top register
  p_ptr_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ptr <= TOP);
endmodule

// File: rtl/sreg_port.sv
`timescale 1ns/1ps
module sreg_port #(
  parameter int         NREG   = 26,
  parameter int         SYNC   = 2,
  parameter logic [5:0] DEV_HI = 6'b100110,
  localparam int        AW     = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  input  logic          addr_sel_i,
  output logic          sda_pull_o,
  output logic          wr_stb_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [7:0]    wr_data_o,
  input  logic [AW-1:0] host_raddr_i,
  output logic [7:0]    host_rdata_o
);
  logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_p, stop_p;
  logic [AW-1:0] seq_raddr;
  logic [7:0]    seq_rdata;

  sreg_sync #(.STAGES(SYNC)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl_i),
    .sda_i    (sda_i),
    .scl_lvl  (scl_lvl),
    .sda_lvl  (sda_lvl),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_p  (start_p),
    .stop_p   (stop_p)
  );

  sreg_seq #(.NREG(NREG), .AW(AW), .DEV_HI(DEV_HI)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_lvl  (scl_lvl),
    .sda_lvl  (sda_lvl),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_p  (start_p),
    .stop_p   (stop_p),
    .addr_sel (addr_sel_i),
    .rd_data  (seq_rdata),
    .rd_addr  (seq_raddr),
    .wr_stb   (wr_stb_o),
    .wr_addr  (wr_addr_o),
    .wr_data  (wr_data_o),
    .sda_pull (sda_pull_o)
  );

  sreg_bank #(.NREG(NREG), .AW(AW)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_stb_o),
    .wr_addr (wr_addr_o),
    .wr_data (wr_data_o),
    .ra_addr (host_raddr_i),
    .ra_data (host_rdata_o),
    .rb_addr (seq_raddr),
    .rb_data (seq_rdata)
  );
endmodule

// File: tb/sim_sreg_port.sv
`timescale 1ns/1ps
module sim_sreg_port;
  localparam int Q = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sel_m = 1'b0;
  logic [4:0] host_raddr = '0;
  logic sda_pull, wr_stb;
  logic [4:0] wr_addr;
  logic [7:0] wr_data, host_rdata;
  logic sda_ln;

  assign sda_ln = sda_m & ~sda_pull;

  always #4 clk = ~clk;

  sreg_port u0 (
    .clk          (clk),
    .rst_n        (rst_n),
    .scl_i        (scl_m),
    .sda_i        (sda_ln),
    .addr_sel_i   (sel_m),
    .sda_pull_o   (sda_pull),
    .wr_stb_o     (wr_stb),
    .wr_addr_o    (wr_addr),
    .wr_data_o    (wr_data),
    .host_raddr_i (host_raddr),
    .host_rdata_o (host_rdata)
  );

  int n_chk = 0;
  int n_err = 0;
  int n_stb = 0;
  int n_viol = 0;
  logic prev_pull = 1'b0;
  logic [7:0] shadow [26];

  // fields: sel | bus addr(7) | base(8) | data(8) | addr ack | base ack
  localparam logic [25:0] VEC [7] = '{
    {1'b0, 7'h4C, 8'h03, 8'hA5, 1'b1, 1'b1},
    {1'b1, 7'h4D, 8'h07, 8'h3C, 1'b1, 1'b1},
    {1'b0, 7'h4D, 8'h10, 8'h77, 1'b0, 1'b0},
    {1'b1, 7'h4C, 8'h10, 8'h66, 1'b0, 1'b0},
    {1'b0, 7'h4C, 8'h19, 8'h5A, 1'b1, 1'b1},
    {1'b0, 7'h4C, 8'h1A, 8'h11, 1'b1, 1'b0},
    {1'b1, 7'h4D, 8'h00, 8'hFF, 1'b1, 1'b1}
  };

  always @(negedge clk) begin
    if (rst_n) begin
      if (wr_stb) n_stb++;
      if (sda_pull != prev_pull && scl_m) n_viol++;
    end
    prev_pull = sda_pull;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_start();
    sda_m = 1'b1; wt(Q);
    scl_m = 1'b1; wt(Q);
    sda_m = 1'b0; wt(Q);
    scl_m = 1'b0; wt(2);
  endtask

  task automatic do_stop();
    sda_m = 1'b0; wt(Q);
    scl_m = 1'b1; wt(Q);
    sda_m = 1'b1; wt(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ackd);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wt(Q);
      scl_m = 1'b1; wt(Q);
      scl_m = 1'b0; wt(2);
    end
    sda_m = 1'b1; wt(Q);
    scl_m = 1'b1; wt(Q/2);
    ackd = !sda_ln; wt(Q/2);
    scl_m = 1'b0; wt(2);
  endtask

  task automatic recv_byte(input logic nack, output logic [7:0] d);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wt(Q);
      scl_m = 1'b1; wt(Q/2);
      d[i] = sda_ln; wt(Q/2);
      scl_m = 1'b0; wt(2);
    end
    sda_m = nack; wt(Q);
    scl_m = 1'b1; wt(Q);
    scl_m = 1'b0; wt(2);
    sda_m = 1'b1;
  endtask

  task automatic hread(input logic [4:0] a, output logic [7:0] d);
    host_raddr = a;
    #1;
    d = host_rdata;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    logic a, b, c;
    logic [7:0] d;
    logic [25:0] v;
    int bi;
    for (int i = 0; i < 26; i++) shadow[i] = 8'h00;
    wt(5);
    rst_n = 1'b1;
    wt(3);

    // R11: reset state
    chk("R11 pull", {31'b0, sda_pull}, 0);
    chk("R11 strobe", {31'b0, wr_stb}, 0);
    begin
      int nz;
      nz = 0;
      for (int i = 0; i < 26; i++) begin
        hread(5'(i), d);
        if (d != 8'h00) nz++;
      end
      chk("R11 bank zero", nz, 0);
    end

    // table-driven single-register writes
    for (int k = 0; k < 7; k++) begin
      v = VEC[k];
      sel_m = v[25];
      wt(Q);
      do_start();
      send_byte({v[24:18], 1'b0}, a);
      chk(v[1] ? "R2 addr ack" : "R3 addr nack", {31'b0, a}, {31'b0, v[1]});
      if (a) begin
        send_byte(v[17:10], b);
        chk(v[0] ? "R4 base ack" : "R6 base nack", {31'b0, b}, {31'b0, v[0]});
        if (b) begin
          send_byte(v[9:2], c);
          chk("R4 data ack", {31'b0, c}, 1);
          shadow[v[14:10]] = v[9:2];
        end
      end
      do_stop();
      if (v[17:10] <= 8'h19) begin
        bi = int'(v[17:10]);
        hread(v[14:10], d);
        chk(v[1] ? "R4 readback" : "R3 no write", d, shadow[bi]);
      end
    end
    sel_m = 1'b0;

    // R1: a bare start and stop leave the block ready for a clean transfer
    do_start();
    do_stop();
    do_start();
    send_byte(8'h98, a);
    chk("R1 addr ack after stop", {31'b0, a}, 1);
    send_byte(8'h04, b);
    send_byte(8'h5E, c);
    do_stop();
    shadow[4] = 8'h5E;
    hread(5'h04, d);
    chk("R1 write after stop", d, 8'h5E);

    // R4: burst of four bytes from 0Bh
    n_stb = 0;
    do_start();
    send_byte(8'h98, a);
    send_byte(8'h0B, b);
    for (int i = 0; i < 4; i++) begin
      send_byte(8'(8'h11 * (i + 1)), c);
      chk("R4 burst ack", {31'b0, c}, 1);
      shadow[11 + i] = 8'(8'h11 * (i + 1));
    end
    do_stop();
    chk("R4 strobe count", n_stb, 4);
    for (int i = 0; i < 4; i++) begin
      hread(5'(11 + i), d);
      chk("R4 burst data", d, shadow[11 + i]);
    end

    // R5: write saturation at 19h
    do_start();
    send_byte(8'h98, a);
    send_byte(8'h18, b);
    send_byte(8'hD1, c);
    send_byte(8'hD2, c);
    send_byte(8'hD3, c);
    do_stop();
    shadow[24] = 8'hD1;
    shadow[25] = 8'hD3;
    hread(5'h18, d);
    chk("R5 reg 18h", d, 8'hD1);
    hread(5'h19, d);
    chk("R5 reg 19h saturated", d, 8'hD3);
    hread(5'h17, d);
    chk("R5 reg 17h untouched", d, shadow[23]);

    // R7, R9, R12: set base, repeated start, sequential read
    do_start();
    send_byte(8'h98, a);
    send_byte(8'h0B, b);
    do_start();
    send_byte(8'h99, a);
    chk("R9 read addr ack after repeated start", {31'b0, a}, 1);
    for (int i = 0; i < 4; i++) begin
      recv_byte(i == 3, d);
      chk("R7 sequential read", d, shadow[11 + i]);
    end
    chk("R8 released after master nack", {31'b0, sda_pull}, 0);
    wt(Q);
    chk("R8 still released", {31'b0, sda_ln}, 1);
    do_stop();

    // R5: read saturation at 19h
    do_start();
    send_byte(8'h98, a);
    send_byte(8'h19, b);
    do_start();
    send_byte(8'h99, a);
    recv_byte(1'b0, d);
    chk("R5 read 19h", d, shadow[25]);
    recv_byte(1'b1, d);
    chk("R5 read stays at 19h", d, shadow[25]);
    do_stop();

    // R6: refused base keeps the stored base
    do_start();
    send_byte(8'h98, a);
    send_byte(8'h07, b);
    do_stop();
    do_start();
    send_byte(8'h98, a);
    send_byte(8'h1A, b);
    chk("R6 base 1Ah refused", {31'b0, b}, 0);
    do_stop();
    do_start();
    send_byte(8'h99, a);
    recv_byte(1'b1, d);
    chk("R6 base kept", d, shadow[7]);
    do_stop();

    // R12: single low bit shows bit order
    do_start();
    send_byte(8'h98, a);
    send_byte(8'h02, b);
    send_byte(8'h01, c);
    do_stop();
    hread(5'h02, d);
    chk("R12 msb first write", d, 8'h01);
    do_start();
    send_byte(8'h98, a);
    send_byte(8'h02, b);
    do_start();
    send_byte(8'h99, a);
    recv_byte(1'b1, d);
    chk("R12 msb first read", d, 8'h01);
    do_stop();

    chk("R10 drive changes only with clock low", n_viol, 0);

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule